// File: doc/BRIEF.md
# Loop Sync Time-Base Generator

This block produces the shared time base for a group of timer modules. Two cascaded prescalers run on the source clock and divide it down to a loop period. Once per loop the block emits a one-cycle loop tick for its own use. It also emits a one-cycle sync pulse that leaves two source cycles ahead of that tick. The lead covers the two-flop synchronizer in the receiving timer, so after synchronization the receiver's copy lines up with the local tick.

The block can be the system master or a slave. As master, its own prescaler chain drives the sync output. As slave, it forwards an external sync input to the sync output, and its loop tick follows that forwarded pulse, so another instance can be the time base. The source and destination clocks have no fixed ratio. A stretcher therefore widens the sync pulse to a fixed number of source cycles. In the destination domain, a one-bit select picks either this widened sync or a pin-level sync. The chosen signal is double-registered and then edge-detected, which gives exactly one single-cycle event per pulse.

Top module: `loop_sync_timebase`

## Requirements
- R1: In master mode, `sync_out` pulses once every (hr_div+1)*(lr_div+1) source cycles. Both fields are coded as the division factor minus one, so hr_div=0 and lr_div=127 give a 128-cycle loop.
- R2: When the loop period is at least 2, each `sync_out` and `loop_tick` pulse is high for exactly one source cycle.
- R3: `loop_tick` is high exactly 2 source cycles after `sync_out` was high, in both modes.
- R4: With `is_master`=1, `ext_sync_in` has no effect on `sync_out`.
- R5: With `is_master`=0, `sync_out` equals `ext_sync_in` in the same source cycle.
- R6: After any cycle in which `sync_out` is high, `sync_wide` is high for exactly STRETCH_LEN source cycles, starting in the next cycle. A new pulse restarts the count.
- R7: With `sel_internal`=1, each separated `sync_wide` pulse produces exactly one `dst_sync_event`, after a two-flop synchronizer in the destination clock.
- R8: With `sel_internal`=0, events come only from `pin_sync_in`, one per pulse, and `sync_wide` activity is ignored.
- R9: Reset clears the prescalers, the lead pipeline and the stretcher. The first master `sync_out` comes at the end of the first full loop period after release.
- R10: `dst_sync_event` is a single destination-cycle pulse, and it occurs once per rising edge of the synchronized source.
- R11: A change to `hr_div` or `lr_div` takes effect only at the next loop boundary, so the running period is neither shortened nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock for the prescalers, lead pipeline and stretcher |
| src_rst | input | 1 | Synchronous active-high reset, source domain |
| is_master | input | 1 | 1 = own prescalers drive sync, 0 = forward external sync |
| hr_div | input | HR_W | High-resolution division factor minus one |
| lr_div | input | LR_W | Loop-resolution division factor minus one |
| ext_sync_in | input | 1 | External loop sync, source-clock synchronous |
| sync_out | output | 1 | One-cycle sync pulse, two cycles ahead of the loop tick |
| loop_tick | output | 1 | One-cycle internal loop-resolution tick |
| sync_wide | output | 1 | Sync pulse widened to STRETCH_LEN source cycles |
| dst_clk | input | 1 | Destination clock of the receiving timer |
| dst_rst | input | 1 | Synchronous active-high reset, destination domain |
| sel_internal | input | 1 | 1 = internal widened sync, 0 = pin sync |
| pin_sync_in | input | 1 | Pin-level sync, asynchronous to dst_clk |
| dst_sync_event | output | 1 | One-cycle sync event in the destination domain |

## Verification
The assertions assume that `ext_sync_in` and the prescale fields change only in step with the source clock. They also assume that STRETCH_LEN source periods span at least two destination periods, and that the loop period is long enough for the widened pulse to fall between loops. The stimulus meets these assumptions in the following ways:
- Source inputs are driven only on falling source edges.
- The clocks run at 8 ns and 13 ns against a stretch of 8 cycles.
- The destination-side checks use loops of 16 cycles or more.
- Pin pulses are held well over two destination periods.
- One directed run with very short loops exercises the source-side checks only.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

    parameter int unsigned HR_W      = 3;
    parameter int unsigned LR_W      = 7;
    parameter int unsigned SYNC_LEAD = 2;

    typedef struct packed {
        logic [HR_W-1:0] hr;
        logic [LR_W-1:0] lr;
    } div_cfg_t;

    typedef enum logic {
        TB_SLAVE  = 1'b0,
        TB_MASTER = 1'b1
    } tb_role_e;

    typedef struct packed {
        logic hr_wrap;
        logic loop_wrap;
    } wrap_t;

    function automatic int unsigned loop_cycles(input div_cfg_t c);
        return (int'(c.hr) + 1) * (int'(c.lr) + 1);
    endfunction

endpackage

// File: rtl/lsync_prescaler.sv
module lsync_prescaler
    import lsync_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg_in,
    output logic     loop_pulse
);

    div_cfg_t        act_q;
    logic [HR_W-1:0] hr_q;
    logic [LR_W-1:0] lr_q;
    wrap_t           wr;

    always_comb begin
        wr.hr_wrap   = (hr_q == act_q.hr);
        wr.loop_wrap = wr.hr_wrap && (lr_q == act_q.lr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hr_q       <= '0;
            lr_q       <= '0;
            act_q      <= cfg_in;
            loop_pulse <= 1'b0;
        end else begin
            loop_pulse <= wr.loop_wrap;
            if (wr.hr_wrap) hr_q <= '0;
            else            hr_q <= hr_q + 1'b1;
            if (wr.loop_wrap) begin
                lr_q  <= '0;
                act_q <= cfg_in;
            end else if (wr.hr_wrap) begin
                lr_q <= lr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lsync_lead.sv
module lsync_lead #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] stage_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b0;
                else     stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/lsync_stretch.sv
module lsync_stretch #(
    parameter int unsigned LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic wide_out
);

    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (pulse_in)      cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign wide_out = (cnt_q != '0);

endmodule

// File: rtl/lsync_rx.sv
module lsync_rx #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_internal,
    input  logic int_sync,
    input  logic pin_sync,
    output logic sync_event
);

    logic              chosen;
    logic [STAGES-1:0] sq;
    logic              prev_q;

    assign chosen = sel_internal ? int_sync : pin_sync;

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sq[g] <= 1'b0;
                else     sq[g] <= chosen;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sq[g] <= 1'b0;
                else     sq[g] <= sq[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sq[STAGES-1];
    end

    assign sync_event = sq[STAGES-1] & ~prev_q;

endmodule

// File: rtl/loop_sync_timebase.sv
module loop_sync_timebase
    import lsync_pkg::*;
#(
    parameter int unsigned STRETCH_LEN = 8,
    parameter int unsigned RX_STAGES   = 2
) (
    input  logic            src_clk,
    input  logic            src_rst,
    input  logic            is_master,
    input  logic [HR_W-1:0] hr_div,
    input  logic [LR_W-1:0] lr_div,
    input  logic            ext_sync_in,
    output logic            sync_out,
    output logic            loop_tick,
    output logic            sync_wide,
    input  logic            dst_clk,
    input  logic            dst_rst,
    input  logic            sel_internal,
    input  logic            pin_sync_in,
    output logic            dst_sync_event
);

    div_cfg_t cfg;
    tb_role_e role;
    logic     gen_pulse;

    assign cfg.hr = hr_div;
    assign cfg.lr = lr_div;
    assign role   = tb_role_e'(is_master);

    lsync_prescaler u_presc (
        .clk        (src_clk),
        .rst        (src_rst),
        .cfg_in     (cfg),
        .loop_pulse (gen_pulse)
    );

    assign sync_out = (role == TB_MASTER) ? gen_pulse : ext_sync_in;

    lsync_lead #(.DEPTH(SYNC_LEAD)) u_lead (
        .clk  (src_clk),
        .rst  (src_rst),
        .din  (sync_out),
        .dout (loop_tick)
    );

    lsync_stretch #(.LEN(STRETCH_LEN)) u_str (
        .clk      (src_clk),
        .rst      (src_rst),
        .pulse_in (sync_out),
        .wide_out (sync_wide)
    );

    lsync_rx #(.STAGES(RX_STAGES)) u_rx (
        .clk          (dst_clk),
        .rst          (dst_rst),
        .sel_internal (sel_internal),
        .int_sync     (sync_wide),
        .pin_sync     (pin_sync_in),
        .sync_event   (dst_sync_event)
    );

endmodule

// File: rtl/lsync_checker.sv
module lsync_checker (
    input logic src_clk,
    input logic src_rst,
    input logic sync_out,
    input logic loop_tick,
    input logic sync_wide,
    input logic dst_clk,
    input logic dst_rst,
    input logic dst_sync_event
);

    logic [1:0] age_q;

    always_ff @(posedge src_clk) begin
        if (src_rst)             age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    AST_TICK_LAGS_SYNC: assert property (@(posedge src_clk) disable iff (src_rst)
        (age_q >= 2'd2) |-> (loop_tick == $past(sync_out, 2))); // R3

    AST_WIDE_FOLLOWS: assert property (@(posedge src_clk) disable iff (src_rst)
        sync_out |=> sync_wide); // R6

    AST_WIDE_HOLDS: assert property (@(posedge src_clk) disable iff (src_rst)
        $rose(sync_wide) |=> sync_wide); // R6

    AST_RESET_CLEARS: assert property (@(posedge src_clk)
        src_rst |=> (!loop_tick && !sync_wide)); // R9

    AST_EVENT_SINGLE: assert property (@(posedge dst_clk) disable iff (dst_rst)
        dst_sync_event |=> !dst_sync_event); // R10

endmodule

bind loop_sync_timebase lsync_checker u_chk (
    .src_clk        (src_clk),
    .src_rst        (src_rst),
    .sync_out       (sync_out),
    .loop_tick      (loop_tick),
    .sync_wide      (sync_wide),
    .dst_clk        (dst_clk),
    .dst_rst        (dst_rst),
    .dst_sync_event (dst_sync_event)
);

// File: tb/sim_loop_sync_timebase.sv
`timescale 1ns/1ps
module sim_loop_sync_timebase;
    import lsync_pkg::*;

    localparam int unsigned LEN = 8;

    logic            src_clk = 1'b0;
    logic            dst_clk = 1'b0;
    logic            src_rst = 1'b1;
    logic            dst_rst = 1'b1;
    logic            drv_master = 1'b1;
    logic            drv_ext = 1'b0;
    div_cfg_t        drv_cfg;
    logic            sel_internal = 1'b1;
    logic            pin_sync_in = 1'b0;
    logic            sync_out, loop_tick, sync_wide, dst_sync_event;

    logic            pend_master = 1'b1;
    logic            pend_ext = 1'b0;
    div_cfg_t        pend_cfg;

    int  vectors = 0;
    int  fails = 0;
    int  e = 0;
    int  exp_next = 0;
    int  first_p = 0;
    int  last_k = -1000;
    int  sent = 0;
    int  ev_cnt = 0;
    bit  h1 = 0, h2 = 0, prev_exp = 0, count_en = 0, cfg_moved = 0, done = 0;

    always #4 src_clk = ~src_clk;
    always #6.5 dst_clk = ~dst_clk;

    loop_sync_timebase #(.STRETCH_LEN(LEN)) u0 (
        .src_clk        (src_clk),
        .src_rst        (src_rst),
        .is_master      (drv_master),
        .hr_div         (drv_cfg.hr),
        .lr_div         (drv_cfg.lr),
        .ext_sync_in    (drv_ext),
        .sync_out       (sync_out),
        .loop_tick      (loop_tick),
        .sync_wide      (sync_wide),
        .dst_clk        (dst_clk),
        .dst_rst        (dst_rst),
        .sel_internal   (sel_internal),
        .pin_sync_in    (pin_sync_in),
        .dst_sync_event (dst_sync_event)
    );

    always @(negedge dst_clk) if (!dst_rst && dst_sync_event) ev_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at step %0d: actual %0d expected %0d", req, e, act, expv);
        end
    endtask

    function automatic div_cfg_t mk(input int hr, input int lr);
        div_cfg_t c;
        c.hr = HR_W'(hr);
        c.lr = LR_W'(lr);
        return c;
    endfunction

    task automatic step();
        bit gen, sexp, snow;
        int wdist;
        string lbl;
        @(negedge src_clk);
        gen = 0;
        if (!src_rst) begin
            e++;
            gen = (e == exp_next);
            if (gen) begin
                exp_next = e + int'(loop_cycles(drv_cfg));
            end
            sexp = drv_master ? gen : drv_ext;
            if (!drv_master)               lbl = "R5";
            else if (gen && e == first_p)  lbl = "R9";
            else if (gen && cfg_moved)     lbl = "R11";
            else if (prev_exp && !sexp)    lbl = "R2";
            else if (drv_ext && !sexp)     lbl = "R4";
            else                           lbl = "R1";
            chk(sync_out == sexp, lbl, int'(sync_out), int'(sexp));
            chk(loop_tick == h2, "R3", int'(loop_tick), int'(h2));
            wdist = e - last_k;
            chk(sync_wide == (wdist <= int'(LEN)), "R6", int'(sync_wide), int'(wdist <= int'(LEN)));
            if (gen) cfg_moved = 0;
            prev_exp = sexp;
        end
        if (pend_cfg != drv_cfg) cfg_moved = 1;
        drv_master = pend_master;
        drv_ext    = pend_ext;
        drv_cfg    = pend_cfg;
        if (!src_rst) begin
            snow = drv_master ? gen : drv_ext;
            h2 = h1;
            h1 = snow;
            if (snow) begin
                last_k = e;
                if (count_en) sent++;
            end
        end
    endtask

    task automatic do_reset();
        pend_ext = 0;
        @(negedge src_clk);
        src_rst = 1'b1;
        drv_ext = 1'b0;
        drv_cfg = pend_cfg;
        drv_master = pend_master;
        repeat (3) @(negedge src_clk);
        chk(sync_out == 1'b0, "R9", int'(sync_out), 0);
        chk(loop_tick == 1'b0, "R9", int'(loop_tick), 0);
        chk(sync_wide == 1'b0, "R9", int'(sync_wide), 0);
        src_rst = 1'b0;
        e = 0;
        exp_next = int'(loop_cycles(drv_cfg));
        first_p = exp_next;
        h1 = 0; h2 = 0; prev_exp = 0; cfg_moved = 0;
        last_k = -1000;
    endtask

    task automatic dst_window(input bit sel, input int pins, input string tag);
        int base;
        pend_master = 0; pend_ext = 0;
        repeat (40) step();
        sel_internal = sel;
        base = ev_cnt;
        if (sel) begin
            sent = 0; count_en = 1;
            pend_master = 1;
            repeat (400) step();
            pend_master = 0;
            repeat (40) step();
            count_en = 0;
            repeat (10) step();
            chk(ev_cnt - base == sent, tag, ev_cnt - base, sent);
        end else begin
            pend_master = 1;
            fork
                repeat (260) step();
                begin
                    repeat (pins) begin
                        #45 pin_sync_in = 1'b1;
                        #45 pin_sync_in = 1'b0;
                    end
                end
            join
            repeat (10) step();
            chk(ev_cnt - base == pins, tag, ev_cnt - base, pins);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        int hr, lr, runlen, cut;
        void'($urandom(32'd1234));
        drv_cfg  = mk(0, 127);
        pend_cfg = mk(0, 127);
        repeat (4) @(negedge dst_clk);
        dst_rst = 1'b0;

        // R1 R9: 1 x 128 loop from reset
        do_reset();
        repeat (300) step();

        // R2 R3: very short loops
        pend_cfg = mk(0, 0);
        repeat (140) step();
        pend_cfg = mk(1, 0);
        repeat (30) step();
        pend_cfg = mk(2, 4);
        repeat (40) step();

        // R4 R5 R11: random modes, fields and external pulses
        for (int r = 0; r < 24; r++) begin
            hr = int'($urandom % 4);
            lr = 15 + int'($urandom % 30);
            pend_cfg = mk(hr, lr);
            pend_master = ($urandom % 3) != 0;
            runlen = 60 + int'($urandom % 240);
            cut = int'($urandom % runlen);
            for (int s = 0; s < runlen; s++) begin
                pend_ext = ($urandom % 6) == 0;
                if (s == cut) pend_cfg = mk(int'($urandom % 4), 15 + int'($urandom % 30));
                step();
            end
        end
        pend_ext = 0;

        // R7 R10: internal path into destination domain
        pend_cfg = mk(1, 9);
        dst_window(1'b1, 0, "R7 R10");
        // R8: pin path, internal activity ignored
        dst_window(1'b0, 10, "R8");
        dst_window(1'b1, 0, "R7");

        // R9: reset in the middle of a stretched pulse
        pend_master = 1;
        pend_cfg = mk(0, 19);
        while (!sync_wide) step();
        do_reset();
        repeat (60) step();

        summary();
    end

endmodule